// File: doc/BRIEF.md
# Edge-Triggered Interrupt Line Controller

This block turns up to sixteen external pins into edge-triggered interrupt requests. Each of the sixteen lines takes pin n (its own line number) from one of several 16-bit GPIO banks. A 4-bit selector, set by software, names that bank. The chosen pin passes through a two-stage synchronizer. The block then compares it against a delayed copy to find rising and falling transitions.

An enabled transition latches a pending flag for that line. Software clears a pending flag by writing a one to it. A per-line unmask bit decides whether the flag reaches the request outputs. Lines 0 to 4 each drive a request output of their own. Lines 5 to 9 share one request, and lines 10 to 15 share another.

Software reaches all configuration through a small word-addressed register bus. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `exti_ctrl`

## Requirements
- R1: After reset every register reads 0 at every address 0 to 15, and all request outputs are low.
- R2: The register map is as follows. Address 0 holds the unmask bits and address 1 the rising enables. Address 2 holds the falling enables and address 3 the pending flags. Addresses 4 to 7 hold selector words 0 to 3. A write to 0, 1, 2 or 4 to 7 stores the 16-bit write data, and a read returns it. Addresses 8 to 15 read 0, and writes to them change nothing.
- R3: Line n takes pin `pins_i[b*16+n]`. Here b is the 4-bit field at bits (n mod 4)*4+3 down to (n mod 4)*4 of selector word n/4. A value of b equal to or above the bank count gives a constant low source.
- R4: With its rising enable set, a 0-to-1 change of the selected pin sets the line's pending flag. The change is applied just after a clock edge, and the flag reads 1 after the third following rising clock edge and not before.
- R5: With its falling enable set, a 1-to-0 change of the selected pin sets the pending flag with the same latency.
- R6: With both enables set, either direction of change sets the pending flag.
- R7: A pending flag never becomes set unless an enabled edge was detected on that line. A line with neither enable set never sets its flag.
- R8: Writing to address 3 clears each pending bit whose write data bit is 1 and leaves the bits written with 0 unchanged. Such a write never sets a bit.
- R9: If an enabled edge and a clearing write to the same pending bit land on the same clock edge, the bit stays set.
- R10: A pending flag latches regardless of its unmask bit. The flag reaches the outputs only while its unmask bit is 1, so setting the unmask bit later raises the request.
- R11: `irq_line_o[k]` is pending[k] AND unmask[k] for k in 0 to 4. `irq_mid_o` is the OR of that product over lines 5 to 9, and `irq_hi_o` is the OR over lines 10 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pins_i | input | NUM_BANKS*16 | All bank pins, bank b at bits b*16+15 down to b*16 |
| irq_line_o | output | 5 | Individual requests for lines 0 to 4 |
| irq_mid_o | output | 1 | Shared request for lines 5 to 9 |
| irq_hi_o | output | 1 | Shared request for lines 10 to 15 |

## Verification
Corrupt synchronizer or edge state shows up as a pending flag that sets one cycle early or late, or sets on the wrong direction. A cycle-accurate model catches this at the first request output that differs, and the exact three-edge latency read catches it directly. A wrong selector decode shows up as a line that responds to a pin in another bank or ignores its own, within three cycles of the toggle. A broken clear or collision path leaves a request high or low one cycle after the write to address 3.

// File: rtl/exti_pkg.sv
package exti_pkg;
    parameter int LINES       = 16;
    parameter int BANK_PINS   = 16;
    parameter int SEL_W       = 4;
    parameter int FIELDS_WORD = 4;
    parameter int SEL_WORDS   = LINES / FIELDS_WORD;
    parameter int ADDR_W      = 4;
    parameter int DATA_W      = 16;

    localparam logic [ADDR_W-1:0] A_UNMASK = 4'd0;
    localparam logic [ADDR_W-1:0] A_RISE   = 4'd1;
    localparam logic [ADDR_W-1:0] A_FALL   = 4'd2;
    localparam logic [ADDR_W-1:0] A_PEND   = 4'd3;
    localparam int                SEL_BASE = 4;

    localparam int SOLO_LINES = 5;
    localparam int MID_LO     = 5;
    localparam int MID_HI     = 9;
    localparam int HI_LO      = 10;
    localparam int HI_HI      = 15;
endpackage

// File: rtl/exti_line.sv
module exti_line
    import exti_pkg::*;
#(
    parameter int NUM_BANKS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_pin,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 rise_en,
    input  logic                 fall_en,
    output logic                 edge_ev
);
    logic src;
    logic sync1_q, sync2_q, prev_q;
    logic rise_hit, fall_hit;

    always_comb begin
        src = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel == SEL_W'(b)) src = bank_pin[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= src;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign rise_hit = rise_en & sync2_q & ~prev_q;
    assign fall_hit = fall_en & ~sync2_q & prev_q;
    assign edge_ev  = rise_hit | fall_hit;

    // R4: a rising hit means the synchronized pin was low one cycle ago
    assert_rise_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_hit |-> (sync2_q && !$past(sync2_q)));

    // R5: a falling hit means the synchronized pin was high one cycle ago
    assert_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_hit |-> (!sync2_q && $past(sync2_q)));
endmodule

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       we,
    input  logic [LINES-1:0]           edge_ev,
    output logic [LINES-1:0]           unmask_q,
    output logic [LINES-1:0]           rise_q,
    output logic [LINES-1:0]           fall_q,
    output logic [LINES-1:0]           pend_q,
    output logic [SEL_WORDS*DATA_W-1:0] sel_flat,
    output logic [DATA_W-1:0]          rdata
);
    logic [LINES-1:0] clr_mask;
    logic [SEL_WORDS-1:0][DATA_W-1:0] sel_q;

    assign clr_mask = (we && addr == A_PEND) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unmask_q <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            pend_q   <= '0;
        end else begin
            // an edge in the same cycle wins over the clear
            pend_q <= (pend_q & ~clr_mask) | edge_ev;
            if (we && addr == A_UNMASK) unmask_q <= wdata;
            if (we && addr == A_RISE)   rise_q   <= wdata;
            if (we && addr == A_FALL)   fall_q   <= wdata;
        end
    end

    for (genvar i = 0; i < SEL_WORDS; i++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_q[i] <= '0;
            else if (we && addr == ADDR_W'(SEL_BASE + i)) sel_q[i] <= wdata;
        end
        assign sel_flat[i*DATA_W +: DATA_W] = sel_q[i];
    end

    always_comb begin
        rdata = '0;
        if (addr == A_UNMASK) rdata = unmask_q;
        if (addr == A_RISE)   rdata = rise_q;
        if (addr == A_FALL)   rdata = fall_q;
        if (addr == A_PEND)   rdata = pend_q;
        for (int i = 0; i < SEL_WORDS; i++) begin
            if (addr == ADDR_W'(SEL_BASE + i)) rdata = sel_q[i];
        end
    end

    // R9: every detected edge is visible as pending on the next cycle
    assert_edge_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(edge_ev)) == $past(edge_ev)));

    // R7: no pending bit rises without an edge from the line logic
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(edge_ev)) == '0));

    // R2: a write to the unmask word is held afterwards
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_UNMASK) |=> (unmask_q == $past(wdata)));
endmodule

// File: rtl/exti_irq.sv
module exti_irq
    import exti_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LINES-1:0]      pend,
    input  logic [LINES-1:0]      unmask,
    output logic [SOLO_LINES-1:0] irq_line_o,
    output logic                  irq_mid_o,
    output logic                  irq_hi_o
);
    logic [LINES-1:0] live;

    assign live       = pend & unmask;
    assign irq_line_o = live[SOLO_LINES-1:0];
    assign irq_mid_o  = |live[MID_HI:MID_LO];
    assign irq_hi_o   = |live[HI_HI:HI_LO];

    // R10: with every line masked no request is raised
    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask == '0) |-> (irq_line_o == '0 && !irq_mid_o && !irq_hi_o));
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
    import exti_pkg::*;
#(
    parameter int NUM_BANKS = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    input  logic                           bus_we,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_BANKS*BANK_PINS-1:0] pins_i,
    output logic [SOLO_LINES-1:0]          irq_line_o,
    output logic                           irq_mid_o,
    output logic                           irq_hi_o
);
    logic [LINES-1:0] unmask_q, rise_q, fall_q, pend_q, edge_ev;
    logic [SEL_WORDS*DATA_W-1:0] sel_flat;

    exti_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .edge_ev  (edge_ev),
        .unmask_q (unmask_q),
        .rise_q   (rise_q),
        .fall_q   (fall_q),
        .pend_q   (pend_q),
        .sel_flat (sel_flat),
        .rdata    (bus_rdata)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        logic [NUM_BANKS-1:0] column;
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_col
            assign column[b] = pins_i[b*BANK_PINS + n];
        end
        exti_line #(.NUM_BANKS(NUM_BANKS)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .bank_pin (column),
            .sel      (sel_flat[n*SEL_W +: SEL_W]),
            .rise_en  (rise_q[n]),
            .fall_en  (fall_q[n]),
            .edge_ev  (edge_ev[n])
        );
    end

    exti_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend_q),
        .unmask     (unmask_q),
        .irq_line_o (irq_line_o),
        .irq_mid_o  (irq_mid_o),
        .irq_hi_o   (irq_hi_o)
    );

    // R8: clearing everything with no edge in flight silences all requests
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PEND && bus_wdata == '1 && edge_ev == '0)
        |=> (irq_line_o == '0 && !irq_mid_o && !irq_hi_o));
endmodule

// File: tb/exti_ctrl_tb.sv
module exti_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic [NB*16-1:0] pins = '0;
    logic [4:0]  irq_line_o;
    logic        irq_mid_o, irq_hi_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    exti_ctrl #(.NUM_BANKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pins_i(pins),
        .irq_line_o(irq_line_o), .irq_mid_o(irq_mid_o), .irq_hi_o(irq_hi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [15:0] m_unmask = '0, m_rise = '0, m_fall = '0, m_pend = '0;
    logic [15:0] m_sel [4];
    logic [15:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
    logic [15:0] m_src, m_ev, m_clr;
    initial for (int i = 0; i < 4; i++) m_sel[i] = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_unmask = '0; m_rise = '0; m_fall = '0; m_pend = '0;
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
            for (int i = 0; i < 4; i++) m_sel[i] = '0;
        end else begin
            for (int n = 0; n < 16; n++) begin
                int b;
                b = int'((m_sel[n/4] >> ((n%4)*4)) & 16'hF);
                m_src[n] = (b < NB) ? pins[b*16+n] : 1'b0;
            end
            m_ev  = (m_rise & m_s2 & ~m_s3) | (m_fall & ~m_s2 & m_s3);
            m_clr = (bus_we && bus_addr == 4'd3) ? bus_wdata : 16'h0;
            m_pend = (m_pend & ~m_clr) | m_ev;
            if (bus_we) begin
                if (bus_addr == 4'd0) m_unmask = bus_wdata;
                if (bus_addr == 4'd1) m_rise = bus_wdata;
                if (bus_addr == 4'd2) m_fall = bus_wdata;
                if (bus_addr >= 4'd4 && bus_addr <= 4'd7) m_sel[bus_addr-4] = bus_wdata;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = m_src;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of the request outputs against the model (R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] live;
            live = m_pend & m_unmask;
            check("R11 per-cycle requests",
                  {25'd0, irq_hi_o, irq_mid_o, irq_line_o},
                  {25'd0, |live[15:10], |live[9:5], live[4:0]});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(tag, {16'd0, bus_rdata}, {16'd0, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 16; a++) rd(4'(a), 16'h0, "R1 reset read");
        check("R1 reset requests", {25'd0, irq_hi_o, irq_mid_o, irq_line_o}, 32'd0);

        // R2 map and readback
        wr(4'd0, 16'hA5C3); rd(4'd0, 16'hA5C3, "R2 unmask readback");
        wr(4'd1, 16'h1234); rd(4'd1, 16'h1234, "R2 rise readback");
        wr(4'd2, 16'h4321); rd(4'd2, 16'h4321, "R2 fall readback");
        wr(4'd7, 16'hBEEF); rd(4'd7, 16'hBEEF, "R2 sel3 readback");
        wr(4'd9, 16'hFFFF); rd(4'd9, 16'h0, "R2 unused reads 0");
        rd(4'd0, 16'hA5C3, "R2 unused write ignored");
        rd(4'd7, 16'hBEEF, "R2 unused write ignored sel");
        wr(4'd0, 16'h0); wr(4'd1, 16'h0); wr(4'd2, 16'h0); wr(4'd7, 16'h0);
        idle(4); wr(4'd3, 16'hFFFF);

        // R3 select line 5 from bank 2, rising enabled, unmasked
        wr(4'd5, 16'h0020); wr(4'd1, 16'h0020); wr(4'd0, 16'h0020);
        @(negedge clk); pins[5] = 1'b1;     // bank 0 pin 5: not selected
        idle(4);
        rd(4'd3, 16'h0, "R3 other bank ignored");
        @(negedge clk); pins[37] = 1'b1;    // bank 2 pin 5
        rd(4'd3, 16'h0, "R4 not after first edge");
        rd(4'd3, 16'h0, "R4 not after second edge");
        rd(4'd3, 16'h0020, "R4 set after third edge");
        check("R11 mid request", {31'd0, irq_mid_o}, 32'd1);

        // R8 writing zero leaves it, writing one clears
        wr(4'd3, 16'h0); rd(4'd3, 16'h0020, "R8 zero write no effect");
        wr(4'd3, 16'h0020); rd(4'd3, 16'h0, "R8 one write clears");

        // R3 selector beyond bank count is constant low
        wr(4'd5, 16'h0070); idle(4); wr(4'd3, 16'hFFFF);
        @(negedge clk); pins[5] = 1'b0; pins[37] = 1'b0; pins[85] = 1'b0;
        idle(2);
        @(negedge clk); pins[5] = 1'b1; pins[37] = 1'b1; pins[85] = 1'b1;
        idle(5);
        rd(4'd3, 16'h0, "R3 out-of-range selector low");

        // R5 falling on line 0 bank 0, masked first (R10)
        wr(4'd1, 16'h0); wr(4'd0, 16'h0); wr(4'd4, 16'h0);
        @(negedge clk); pins[0] = 1'b1; idle(4);
        wr(4'd2, 16'h0001);
        @(negedge clk); pins[0] = 1'b0; idle(4);
        rd(4'd3, 16'h0001, "R5 falling sets pending");
        check("R10 masked request low", {27'd0, irq_line_o}, 32'd0);
        wr(4'd0, 16'h0001);
        @(negedge clk);
        check("R10 unmask raises request", {27'd0, irq_line_o}, 32'd1);

        // R9 edge and clear on the same clock edge
        wr(4'd1, 16'h0001); wr(4'd2, 16'h0);
        @(negedge clk); pins[0] = 1'b1;
        @(negedge clk);
        wr(4'd3, 16'h0001);                 // lands together with the edge
        rd(4'd3, 16'h0001, "R9 edge wins over clear");
        wr(4'd3, 16'h0001); rd(4'd3, 16'h0, "R9 later clear works");

        // R6 both edges on line 12 bank 5
        wr(4'd7, 16'h0005); wr(4'd1, 16'h1000); wr(4'd2, 16'h1000); wr(4'd0, 16'h1000);
        idle(4); wr(4'd3, 16'hFFFF);
        @(negedge clk); pins[92] = 1'b1; idle(4);
        rd(4'd3, 16'h1000, "R6 rise sets");
        check("R11 high request", {31'd0, irq_hi_o}, 32'd1);
        wr(4'd3, 16'h1000); rd(4'd3, 16'h0, "R6 cleared");
        @(negedge clk); pins[92] = 1'b0; idle(4);
        rd(4'd3, 16'h1000, "R6 fall sets");

        // R7 disabled line never sets; R11 solo grouping on line 3
        wr(4'd1, 16'h0); wr(4'd2, 16'h0); wr(4'd3, 16'hFFFF);
        @(negedge clk); pins[92] = 1'b1; idle(5);
        rd(4'd3, 16'h0, "R7 disabled line silent");
        wr(4'd4, 16'h1000); wr(4'd1, 16'h0008); wr(4'd0, 16'h0008);
        @(negedge clk); pins[19] = 1'b1; idle(4);
        check("R11 solo line 3", {25'd0, irq_hi_o, irq_mid_o, irq_line_o}, 32'h08);

        // random phase, compared each cycle with the model
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 3) == 0) wr(4'($urandom_range(0, 8)), 16'($urandom));
            else begin
                @(negedge clk);
                pins[$urandom_range(0, NB*16-1)] ^= 1'b1;
            end
        end
        rd(4'd3, m_pend, "R7 random pending matches");
        finish_run();
    end
endmodule